// File: doc/BRIEF.md
# Bus Master Command Translator

This block sits between a host-side request source and the master side of a 32-bit multiplexed address/data bus. Each request arrives with a kind, a 64-bit address, a target device number, a burst flag and a mode bit (conventional or extended), and is taken under a valid/ready handshake. The block turns it into one or two registered address phases, each a command code with an address/data word. Requests that must not reach the bus get a one-cycle abort response instead.

The command set is deliberately narrow. Memory traffic uses plain read and write commands, or the block read command for reads in extended mode. Configuration traffic uses type-0 read and write commands with a one-hot device-select bit in the upper half of the word. I/O traffic uses I/O read and write commands. Memory addresses with any nonzero upper word go out as a dual-address cycle: a DAC phase followed by the real command carrying the upper word. While that second phase is pending, no new request is taken.

Top module: `bus_cmd_xlate`

## Requirements
- R1: While reset is held, and in the first cycles after it, `ap_valid` and `rsp_valid` are 0 and `req_ready` is 1.
- R2: Request kinds are encoded as memory read 3'd0, memory write 3'd1, config read 3'd2, config write 3'd3, I/O read 3'd4, I/O write 3'd5. A memory read issues 4'b0110 in conventional mode (`req_xmode`=0) and 4'b1110 in extended mode. A memory write issues 4'b0111 in both modes. The codes 4'b0000, 4'b1100 and 4'b1111 are never issued.
- R3: If a memory request has a nonzero address[63:32], the block issues a first phase with command 4'b1101 and `ap_ad`=address[31:0], with `ap_last`=0. The following cycle carries the real command with `ap_ad`=address[63:32] and `ap_last`=1.
- R4: If address[63:32] is zero, a memory request is issued as a single phase with `ap_last`=1. That phase appears in the cycle after the request is accepted.
- R5: Config reads use 4'b1010 and config writes use 4'b1011. The address word has bit 16+device set as the only set bit in [31:16], bits [15:8] at zero, bits [7:2] copied from address[7:2], and bits [1:0] at 00.
- R6: A config request (not burst) whose device number is above 15 issues no phase. It returns `rsp_status`=2'b10 (master abort).
- R7: A burst I/O request or a burst config request issues no phase. It returns `rsp_status`=2'b01 (target abort). This takes priority over any master-abort cause.
- R8: A non-burst I/O read issues 4'b0010 and an I/O write issues 4'b0011, with `ap_ad`=address[31:0]. If any of address[63:25] is set, the request issues no phase and returns `rsp_status`=2'b10.
- R9: `req_ready` is 0 while the second phase of a dual-address cycle is pending. A request held valid across that cycle is accepted right after the second phase is issued.
- R10: An abort response is a single-cycle `rsp_valid` pulse in the cycle after acceptance, with a nonzero status. `rsp_valid` and `ap_valid` are never 1 together.
- R11: A burst memory request is translated exactly like a non-burst one.
- R12: Kinds 3'd6 and 3'd7 issue no phase and return `rsp_status`=2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 3 | Request kind |
| req_addr | input | 64 | Request address |
| req_dev | input | 5 | Target device number for config requests |
| req_burst | input | 1 | Request is a burst |
| req_xmode | input | 1 | 1 = extended bus mode |
| ap_valid | output | 1 | Address phase present |
| ap_cmd | output | 4 | Command code of the phase |
| ap_ad | output | 32 | Address/data word of the phase |
| ap_last | output | 1 | Final address phase of the request |
| rsp_valid | output | 1 | Abort response pulse |
| rsp_status | output | 2 | 01 target abort, 10 master abort |

## Verification
The case that needs care is a new request arriving while the upper-word phase of a dual-address cycle is being sent. The bench holds a config request valid from the cycle the DAC phase appears. It then checks three things: `req_ready` is low at that point, the upper-word phase comes out unchanged in the next cycle, and the held config phase follows right after with its one-hot select. On the assertion side, the checks confirm that an abort pulse never coincides with an address phase and that the DAC command is always followed by a final phase.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef logic [3:0] cmd_t;
  typedef logic [1:0] status_t;
  typedef logic [2:0] kind_t;

  localparam kind_t KIND_MEM_RD = 3'd0;
  localparam kind_t KIND_MEM_WR = 3'd1;
  localparam kind_t KIND_CFG_RD = 3'd2;
  localparam kind_t KIND_CFG_WR = 3'd3;
  localparam kind_t KIND_IO_RD  = 3'd4;
  localparam kind_t KIND_IO_WR  = 3'd5;

  localparam cmd_t CMD_IO_RD  = 4'b0010;
  localparam cmd_t CMD_IO_WR  = 4'b0011;
  localparam cmd_t CMD_MEM_RD = 4'b0110;
  localparam cmd_t CMD_MEM_WR = 4'b0111;
  localparam cmd_t CMD_CFG_RD = 4'b1010;
  localparam cmd_t CMD_CFG_WR = 4'b1011;
  localparam cmd_t CMD_DAC    = 4'b1101;
  localparam cmd_t CMD_MRB    = 4'b1110;

  localparam status_t ST_OK     = 2'b00;
  localparam status_t ST_TABORT = 2'b01;
  localparam status_t ST_MABORT = 2'b10;
endpackage

// File: rtl/bct_cfg_addr.sv
module bct_cfg_addr #(
  parameter int AD_W    = 32,
  parameter int DEV_W   = 5,
  parameter int NUM_DEV = 16,
  parameter int OFF_W   = 6
) (
  input  logic [DEV_W-1:0] dev,
  input  logic [OFF_W-1:0] reg_off,
  output logic [AD_W-1:0]  cfg_ad
);
  localparam int SEL_LO = AD_W - NUM_DEV;

  logic [NUM_DEV-1:0] sel;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
    assign sel[i] = (dev == DEV_W'(i));
  end

  always_comb begin
    cfg_ad                   = '0;
    cfg_ad[SEL_LO +: NUM_DEV] = sel;
    cfg_ad[2 +: OFF_W]       = reg_off;
  end
endmodule

// File: rtl/bct_decode.sv
module bct_decode
  import bct_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int AD_W    = 32,
  parameter int DEV_W   = 5,
  parameter int NUM_DEV = 16,
  parameter int IO_W    = 25
) (
  input  kind_t             kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DEV_W-1:0]  dev,
  input  logic              burst,
  input  logic              xmode,
  input  logic [AD_W-1:0]   cfg_ad,
  output status_t           status,
  output logic              dac,
  output cmd_t              ph0_cmd,
  output logic [AD_W-1:0]   ph0_ad,
  output cmd_t              ph1_cmd,
  output logic [AD_W-1:0]   ph1_ad
);
  logic hi_nz, io_hi_nz, dev_bad;
  logic is_mem, is_cfg, is_io;
  cmd_t real_cmd;

  assign hi_nz    = |addr[ADDR_W-1:AD_W];
  assign io_hi_nz = |addr[ADDR_W-1:IO_W];
  assign dev_bad  = dev > DEV_W'(NUM_DEV - 1);

  always_comb begin
    is_mem   = 1'b0;
    is_cfg   = 1'b0;
    is_io    = 1'b0;
    real_cmd = CMD_MEM_RD;
    status   = ST_OK;
    case (kind)
      KIND_MEM_RD: begin is_mem = 1'b1; real_cmd = xmode ? CMD_MRB : CMD_MEM_RD; end
      KIND_MEM_WR: begin is_mem = 1'b1; real_cmd = CMD_MEM_WR; end
      KIND_CFG_RD: begin is_cfg = 1'b1; real_cmd = CMD_CFG_RD; end
      KIND_CFG_WR: begin is_cfg = 1'b1; real_cmd = CMD_CFG_WR; end
      KIND_IO_RD:  begin is_io  = 1'b1; real_cmd = CMD_IO_RD;  end
      KIND_IO_WR:  begin is_io  = 1'b1; real_cmd = CMD_IO_WR;  end
      default:     status = ST_MABORT;
    endcase

    if ((is_io || is_cfg) && burst)  status = ST_TABORT;
    else if (is_cfg && dev_bad)      status = ST_MABORT;
    else if (is_io && io_hi_nz)      status = ST_MABORT;

    dac     = is_mem && hi_nz;
    ph1_cmd = real_cmd;
    ph1_ad  = addr[ADDR_W-1:AD_W];
    if (dac) begin
      ph0_cmd = CMD_DAC;
      ph0_ad  = addr[AD_W-1:0];
    end else begin
      ph0_cmd = real_cmd;
      ph0_ad  = is_cfg ? cfg_ad : addr[AD_W-1:0];
    end
  end
endmodule

// File: rtl/bct_sequencer.sv
module bct_sequencer
  import bct_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  status_t         status_i,
  input  logic            dac_i,
  input  cmd_t            ph0_cmd,
  input  logic [AD_W-1:0] ph0_ad,
  input  cmd_t            ph1_cmd,
  input  logic [AD_W-1:0] ph1_ad,
  output logic            ap_valid,
  output cmd_t            ap_cmd,
  output logic [AD_W-1:0] ap_ad,
  output logic            ap_last,
  output logic            rsp_valid,
  output status_t         rsp_status
);
  logic            ap_valid_q, ap_valid_n, ap_last_q, ap_last_n, ap_en;
  cmd_t            ap_cmd_q, ap_cmd_n;
  logic [AD_W-1:0] ap_ad_q, ap_ad_n;
  logic            rsp_valid_q, rsp_valid_n, rsp_en;
  status_t         rsp_status_q;
  logic            pend_q, pend_n, pend_en;
  cmd_t            pend_cmd_q;
  logic [AD_W-1:0] pend_ad_q;

  assign req_ready = !pend_q;

  always_comb begin
    ap_valid_n  = 1'b0;
    ap_last_n   = 1'b0;
    ap_cmd_n    = ap_cmd_q;
    ap_ad_n     = ap_ad_q;
    rsp_valid_n = 1'b0;
    pend_n      = 1'b0;
    pend_en     = 1'b0;
    if (pend_q) begin
      ap_valid_n = 1'b1;
      ap_cmd_n   = pend_cmd_q;
      ap_ad_n    = pend_ad_q;
      ap_last_n  = 1'b1;
    end else if (req_valid) begin
      if (status_i != ST_OK) begin
        rsp_valid_n = 1'b1;
      end else begin
        ap_valid_n = 1'b1;
        ap_cmd_n   = ph0_cmd;
        ap_ad_n    = ph0_ad;
        ap_last_n  = !dac_i;
        pend_n     = dac_i;
        pend_en    = dac_i;
      end
    end
  end

  assign ap_en  = ap_valid_n;
  assign rsp_en = rsp_valid_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_valid_q   <= 1'b0;
      ap_last_q    <= 1'b0;
      ap_cmd_q     <= '0;
      ap_ad_q      <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= ST_OK;
      pend_q       <= 1'b0;
      pend_cmd_q   <= '0;
      pend_ad_q    <= '0;
    end else begin
      ap_valid_q  <= ap_valid_n;
      rsp_valid_q <= rsp_valid_n;
      pend_q      <= pend_n;
      if (ap_en) begin
        ap_cmd_q  <= ap_cmd_n;
        ap_ad_q   <= ap_ad_n;
        ap_last_q <= ap_last_n;
      end
      if (rsp_en) rsp_status_q <= status_i;
      if (pend_en) begin
        pend_cmd_q <= ph1_cmd;
        pend_ad_q  <= ph1_ad;
      end
    end
  end

  assign ap_valid   = ap_valid_q;
  assign ap_cmd     = ap_cmd_q;
  assign ap_ad      = ap_ad_q;
  assign ap_last    = ap_last_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_status_q;

  // R10
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ap_valid_q && rsp_valid_q));

  // R10
  rsp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q |-> (rsp_status_q != ST_OK));

  // R3
  dac_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid_q && !ap_last_q) |=> (ap_valid_q && ap_last_q && ap_cmd_q != CMD_DAC));

  // R3
  dac_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid_q && ap_cmd_q == CMD_DAC) |-> !ap_last_q);

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid_q && !ap_last_q) |-> !req_ready);

  // R2
  no_banned_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_valid_q |-> (ap_cmd_q != 4'b0000 && ap_cmd_q != 4'b1100 && ap_cmd_q != 4'b1111));

  // R5
  cfg_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid_q && (ap_cmd_q == CMD_CFG_RD || ap_cmd_q == CMD_CFG_WR))
      |-> ($onehot(ap_ad_q[31:16]) && ap_ad_q[15:8] == 8'h00 && ap_ad_q[1:0] == 2'b00));
endmodule

// File: rtl/bus_cmd_xlate.sv
module bus_cmd_xlate
  import bct_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int AD_W    = 32,
  parameter int DEV_W   = 5,
  parameter int NUM_DEV = 16,
  parameter int IO_W    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic              req_burst,
  input  logic              req_xmode,
  output logic              ap_valid,
  output logic [3:0]        ap_cmd,
  output logic [AD_W-1:0]   ap_ad,
  output logic              ap_last,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status
);
  localparam int OFF_W = 6;

  logic            rst_meta_q, rst_sync_q;
  logic [AD_W-1:0] cfg_ad, ph0_ad, ph1_ad;
  status_t         status;
  logic            dac;
  cmd_t            ph0_cmd, ph1_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bct_cfg_addr #(
    .AD_W(AD_W), .DEV_W(DEV_W), .NUM_DEV(NUM_DEV), .OFF_W(OFF_W)
  ) u_cfg_addr (
    .dev(req_dev),
    .reg_off(req_addr[2 +: OFF_W]),
    .cfg_ad(cfg_ad)
  );

  bct_decode #(
    .ADDR_W(ADDR_W), .AD_W(AD_W), .DEV_W(DEV_W), .NUM_DEV(NUM_DEV), .IO_W(IO_W)
  ) u_decode (
    .kind(req_kind), .addr(req_addr), .dev(req_dev), .burst(req_burst),
    .xmode(req_xmode), .cfg_ad(cfg_ad), .status(status), .dac(dac),
    .ph0_cmd(ph0_cmd), .ph0_ad(ph0_ad), .ph1_cmd(ph1_cmd), .ph1_ad(ph1_ad)
  );

  bct_sequencer #(.AD_W(AD_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .req_valid(req_valid), .req_ready(req_ready),
    .status_i(status), .dac_i(dac), .ph0_cmd(ph0_cmd), .ph0_ad(ph0_ad),
    .ph1_cmd(ph1_cmd), .ph1_ad(ph1_ad), .ap_valid(ap_valid), .ap_cmd(ap_cmd),
    .ap_ad(ap_ad), .ap_last(ap_last), .rsp_valid(rsp_valid), .rsp_status(rsp_status)
  );
endmodule

// File: tb/bus_cmd_xlate_bench.sv
module bus_cmd_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = 3'd0;
  logic [63:0] req_addr = '0;
  logic [4:0]  req_dev = '0;
  logic        req_burst = 1'b0;
  logic        req_xmode = 1'b0;
  logic        ap_valid, ap_last, rsp_valid;
  logic [3:0]  ap_cmd;
  logic [31:0] ap_ad;
  logic [1:0]  rsp_status;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cmd_xlate u_bus_cmd_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_dev(req_dev),
    .req_burst(req_burst), .req_xmode(req_xmode), .ap_valid(ap_valid),
    .ap_cmd(ap_cmd), .ap_ad(ap_ad), .ap_last(ap_last),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Drive a request for one accepting cycle; return at the negedge where phase one is visible.
  task automatic send(logic [2:0] k, logic [63:0] a, logic [4:0] d, logic b, logic x);
    @(negedge clk);
    req_kind = k; req_addr = a; req_dev = d; req_burst = b; req_xmode = x;
    req_valid = 1'b1;
    chk("R9 ready before accept", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_phase(string tag, logic [3:0] c, logic [31:0] ad, logic last);
    chk({tag, " ap_valid"}, 64'(ap_valid), 64'd1);
    chk({tag, " ap_cmd"}, 64'(ap_cmd), 64'(c));
    chk({tag, " ap_ad"}, 64'(ap_ad), 64'(ad));
    chk({tag, " ap_last"}, 64'(ap_last), 64'(last));
    chk({tag, " no rsp"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic expect_abort(string tag, logic [1:0] st);
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " rsp_status"}, 64'(rsp_status), 64'(st));
    chk({tag, " no phase"}, 64'(ap_valid), 64'd0);
    @(negedge clk);
    chk({tag, " R10 pulse ends"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 ap_valid in reset", 64'(ap_valid), 64'd0);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ap_valid idle", 64'(ap_valid), 64'd0);
    chk("R1 rsp_valid idle", 64'(rsp_valid), 64'd0);
    chk("R1 ready idle", 64'(req_ready), 64'd1);
  endtask

  task automatic t_mem;
    send(3'd0, 64'h0000_0000_1000_0040, 5'd0, 1'b0, 1'b0);
    expect_phase("R2 R4 mem rd conv", 4'b0110, 32'h1000_0040, 1'b1);
    send(3'd0, 64'h0000_0000_2000_0080, 5'd0, 1'b0, 1'b1);
    expect_phase("R2 mem rd ext", 4'b1110, 32'h2000_0080, 1'b1);
    send(3'd1, 64'h0000_0000_3000_00C0, 5'd0, 1'b0, 1'b1);
    expect_phase("R2 mem wr ext", 4'b0111, 32'h3000_00C0, 1'b1);
    send(3'd1, 64'h0000_0000_4000_0100, 5'd0, 1'b1, 1'b0);
    expect_phase("R11 burst mem wr", 4'b0111, 32'h4000_0100, 1'b1);
    @(negedge clk);
    chk("R4 single phase ends", 64'(ap_valid), 64'd0);
  endtask

  task automatic t_dac;
    send(3'd0, 64'h0000_0012_3456_7890, 5'd0, 1'b0, 1'b0);
    expect_phase("R3 dac first", 4'b1101, 32'h3456_7890, 1'b0);
    chk("R9 ready low pending", 64'(req_ready), 64'd0);
    @(negedge clk);
    expect_phase("R3 dac second", 4'b0110, 32'h0000_0012, 1'b1);
    @(negedge clk);
    chk("R3 dac ends", 64'(ap_valid), 64'd0);
  endtask

  task automatic t_cfg;
    send(3'd2, 64'h0000_0000_0000_003C, 5'd0, 1'b0, 1'b0);
    expect_phase("R5 cfg rd dev0", 4'b1010, 32'h0001_003C, 1'b1);
    send(3'd3, 64'h0000_0000_ABCD_EF07, 5'd15, 1'b0, 1'b1);
    expect_phase("R5 cfg wr dev15", 4'b1011, 32'h8000_0004, 1'b1);
    send(3'd2, 64'h0, 5'd16, 1'b0, 1'b0);
    expect_abort("R6 cfg dev16", 2'b10);
    send(3'd3, 64'h0, 5'd3, 1'b1, 1'b0);
    expect_abort("R7 burst cfg", 2'b01);
    send(3'd2, 64'h0, 5'd20, 1'b1, 1'b0);
    expect_abort("R7 burst cfg bad dev", 2'b01);
  endtask

  task automatic t_io;
    send(3'd4, 64'h0000_0000_01FF_FFFF, 5'd0, 1'b0, 1'b0);
    expect_phase("R8 io rd", 4'b0010, 32'h01FF_FFFF, 1'b1);
    send(3'd5, 64'h0000_0000_0000_1234, 5'd0, 1'b0, 1'b1);
    expect_phase("R8 io wr", 4'b0011, 32'h0000_1234, 1'b1);
    send(3'd5, 64'h0000_0000_0200_0000, 5'd0, 1'b0, 1'b0);
    expect_abort("R8 io bit25", 2'b10);
    send(3'd4, 64'h0000_0100_0000_0010, 5'd0, 1'b0, 1'b0);
    expect_abort("R8 io high word", 2'b10);
    send(3'd4, 64'h0000_0000_0000_0010, 5'd0, 1'b1, 1'b0);
    expect_abort("R7 burst io", 2'b01);
    send(3'd6, 64'h0, 5'd0, 1'b0, 1'b0);
    expect_abort("R12 kind6", 2'b10);
    send(3'd7, 64'h0, 5'd0, 1'b0, 1'b0);
    expect_abort("R12 kind7", 2'b10);
  endtask

  // Second DAC phase and a held new request meet in the same cycle.
  task automatic t_overlap;
    @(negedge clk);
    req_kind = 3'd1; req_addr = 64'hFFFF_0000_0000_1000; req_dev = 5'd0;
    req_burst = 1'b0; req_xmode = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    expect_phase("R3 overlap dac", 4'b1101, 32'h0000_1000, 1'b0);
    chk("R9 overlap ready low", 64'(req_ready), 64'd0);
    req_kind = 3'd2; req_addr = 64'h0000_0000_0000_0048; req_dev = 5'd3; req_xmode = 1'b0;
    @(negedge clk);
    expect_phase("R9 overlap upper", 4'b0111, 32'hFFFF_0000, 1'b1);
    chk("R9 overlap ready back", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    expect_phase("R9 R5 held cfg", 4'b1010, 32'h0008_0048, 1'b1);
    @(negedge clk);
    chk("R9 idle after", 64'(ap_valid), 64'd0);
  endtask

  initial begin
    t_reset();
    t_mem();
    t_dac();
    t_cfg();
    t_io();
    t_overlap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule